// File: doc/BRIEF.md
# Shutdown and Wake-up Controller

This block sits in the always-on domain of a chip. It runs from the slow clock and owns the single power-enable signal that keeps the main supply switched on. Software turns the supply off by writing a command word to the control register. That word must carry a password byte in its top eight bits. Any write without the password is dropped, so a stray store cannot cut power.

While power is off, the controller watches three wake-up sources. The first is an external pin, qualified by a level mode and a debounce count. The other two are event strobes from a real-time timer and a real-time clock, and each of these has its own enable. The first enabled source that fires brings power back on the next clock edge. The status register records which sources caused the wake-up. Boot software reads that register once; the read clears it.

Top module: `shdn_wake_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1, the mode register reads 0 and the status register at offset 0x08 reads 0.
- R2: A write to offset 0x00 with bits 31:24 equal to 0xA5 and bit 0 equal to 1 makes `pwr_en` 0 from the clock edge that takes the write. The pin level at that edge is stored as the reference level.
- R3: A write to offset 0x00 has no effect if bits 31:24 are not 0xA5 or if bit 0 is 0. Offset 0x00 always reads as 0.
- R4: The mode register is at offset 0x04. Bits 2:0 hold the pin mode, bits 7:4 the debounce count N, bit 16 the timer-event enable and bit 17 the clock-event enable. The register reads back those fields, and every other bit reads 0.
- R5: Pin modes: 1 wakes while the pin is high and 2 wakes while the pin is low. Codes 0 and 4 to 7 never wake from the pin.
- R6: In pin mode 3, the wake condition is a pin level that differs from the reference level stored at shutdown.
- R7: With debounce count N, the pin condition must be sampled true on N+1 consecutive edges. Power returns from the (N+1)th edge, and a false sample restarts the count.
- R8: While power is off, `rtt_evt` wakes only when bit 16 is set and `rtc_evt` wakes only when bit 17 is set. An enabled event restores power from the next edge.
- R9: A wake-up sets status bit 0 for the pin, bit 16 for the timer event and bit 17 for the clock event. All sources active on that edge are recorded.
- R10: A read of offset 0x08 returns the status and clears it.
- R11: While power is on, wake-up events change neither `pwr_en` nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| wake_pin | input | 1 | External wake-up pin, synchronous to clk |
| rtt_evt | input | 1 | Real-time timer event strobe |
| rtc_evt | input | 1 | Real-time clock event strobe |
| pwr_en | output | 1 | Main supply enable, 1 = on |

## Verification
The bench targets the debounce boundary. It holds the pin condition for exactly N samples, then for N+1, and breaks the run partway through. A counter that is off by one, or that does not restart, wakes one edge early or late, or wakes through the break. The bench also pulses disabled event sources and the pin while power is on, and uses the undefined pin-mode codes. A design that leaks any of these would restore power or set a status bit where it must not. Other checks cover password mismatches, any-level mode with the reference level sampled at shutdown, simultaneous timer and clock events, and the clear-on-read status. A wrong design would show up there as a missed shutdown, a wrong wake edge, a lost status bit or a status that survives its read.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int DATA_W = 32;
  localparam logic [7:0] SHDN_KEY = 8'hA5;

  localparam int OFF_CTL  = 0;
  localparam int OFF_MODE = 4;
  localparam int OFF_STAT = 8;

  localparam int MODE_LIM_LSB = 4;
  localparam int BIT_RTT      = 16;
  localparam int BIT_RTC      = 17;

  typedef enum logic [2:0] {
    PIN_OFF  = 3'd0,
    PIN_HIGH = 3'd1,
    PIN_LOW  = 3'd2,
    PIN_ANY  = 3'd3
  } pin_mode_e;

  // wake-vector index order: {clock, timer, pin}
  typedef logic [2:0] wake_vec_t;

  function automatic logic pin_cond_f(input logic [2:0] mode, input logic pin,
                                      input logic ref_lvl);
    case (mode)
      PIN_HIGH: pin_cond_f = pin;
      PIN_LOW:  pin_cond_f = !pin;
      PIN_ANY:  pin_cond_f = (pin != ref_lvl);
      default:  pin_cond_f = 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input wake_vec_t s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0]       = s[0];
    w[BIT_RTT] = s[1];
    w[BIT_RTC] = s[2];
    return w;
  endfunction

  function automatic logic shdn_word_ok(input logic [DATA_W-1:0] d);
    return (d[DATA_W-1 -: 8] == SHDN_KEY) && d[0];
  endfunction
endpackage

// File: rtl/swc_regfile.sv
module swc_regfile
  import swc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  wake_vec_t         status,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [2:0]        pin_mode,
  output logic [CNT_W-1:0]  wk_limit,
  output logic              rtt_en,
  output logic              rtc_en,
  output logic              shdn_hit,
  output logic              status_rd
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  logic wr_ctl, wr_mode;
  logic [DATA_W-1:0] mode_word;
  logic unused_wdata;

  assign wr_ctl    = bus_sel && bus_wr && (bus_addr == A_CTL);
  assign wr_mode   = bus_sel && bus_wr && (bus_addr == A_MODE);
  assign status_rd = bus_sel && !bus_wr && (bus_addr == A_STAT);
  assign shdn_hit  = wr_ctl && shdn_word_ok(bus_wdata);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_mode <= '0;
      wk_limit <= '0;
      rtt_en   <= 1'b0;
      rtc_en   <= 1'b0;
    end else if (wr_mode) begin
      pin_mode <= bus_wdata[2:0];
      wk_limit <= bus_wdata[MODE_LIM_LSB +: CNT_W];
      rtt_en   <= bus_wdata[BIT_RTT];
      rtc_en   <= bus_wdata[BIT_RTC];
    end
  end

  always_comb begin
    mode_word = '0;
    mode_word[2:0] = pin_mode;
    mode_word[MODE_LIM_LSB +: CNT_W] = wk_limit;
    mode_word[BIT_RTT] = rtt_en;
    mode_word[BIT_RTC] = rtc_en;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_MODE:  bus_rdata = mode_word;
        A_STAT:  bus_rdata = pack_status(status);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/swc_pin_qual.sv
module swc_pin_qual
  import swc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             shdn_accept,
  input  logic [2:0]       pin_mode,
  input  logic [CNT_W-1:0] wk_limit,
  input  logic             wake_pin,
  output logic             pin_cond,
  output logic             pin_wake
);
  logic             ref_q;
  logic [CNT_W-1:0] cnt_q;

  assign pin_cond = armed && pin_cond_f(pin_mode, wake_pin, ref_q);
  assign pin_wake = pin_cond && (cnt_q >= wk_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else if (shdn_accept) ref_q <= wake_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!pin_cond) cnt_q <= '0;
    else if (cnt_q < wk_limit) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/swc_power_core.sv
module swc_power_core
  import swc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shdn_hit,
  input  logic      pin_wake,
  input  logic      rtt_evt,
  input  logic      rtc_evt,
  input  logic      rtt_en,
  input  logic      rtc_en,
  input  logic      status_rd,
  output logic      pwr_en,
  output logic      shdn_accept,
  output wake_vec_t wake_vec,
  output logic      wake_any,
  output wake_vec_t status_q
);
  assign shdn_accept = shdn_hit && pwr_en;
  assign wake_vec = pwr_en ? '0 : {rtc_evt && rtc_en, rtt_evt && rtt_en, pin_wake};
  assign wake_any = |wake_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_en <= 1'b1;
    else if (wake_any) pwr_en <= 1'b1;
    else if (shdn_accept) pwr_en <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else status_q <= (status_rd ? '0 : status_q) | wake_vec;
  end
endmodule

// File: rtl/shdn_wake_ctrl.sv
module shdn_wake_ctrl
  import swc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wake_pin,
  input  logic              rtt_evt,
  input  logic              rtc_evt,
  output logic              pwr_en
);
  logic [2:0]       pin_mode;
  logic [CNT_W-1:0] wk_limit;
  logic             rtt_en, rtc_en;
  logic             shdn_hit, shdn_accept, status_rd;
  logic             pin_cond, pin_wake, wake_any;
  wake_vec_t        wake_vec, status_q;

  swc_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status_q),
    .bus_rdata(bus_rdata), .pin_mode(pin_mode), .wk_limit(wk_limit),
    .rtt_en(rtt_en), .rtc_en(rtc_en), .shdn_hit(shdn_hit),
    .status_rd(status_rd)
  );

  swc_pin_qual #(.CNT_W(CNT_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .armed(!pwr_en), .shdn_accept(shdn_accept),
    .pin_mode(pin_mode), .wk_limit(wk_limit), .wake_pin(wake_pin),
    .pin_cond(pin_cond), .pin_wake(pin_wake)
  );

  swc_power_core u_core (
    .clk(clk), .rst_n(rst_n), .shdn_hit(shdn_hit), .pin_wake(pin_wake),
    .rtt_evt(rtt_evt), .rtc_evt(rtc_evt), .rtt_en(rtt_en), .rtc_en(rtc_en),
    .status_rd(status_rd), .pwr_en(pwr_en), .shdn_accept(shdn_accept),
    .wake_vec(wake_vec), .wake_any(wake_any), .status_q(status_q)
  );
endmodule

// File: rtl/swc_checks.sv
module swc_checks #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              pwr_en,
  input logic              shdn_accept,
  input logic              status_rd,
  input logic              pin_cond,
  input logic              pin_wake,
  input logic              wake_any,
  input logic [2:0]        status_q,
  input logic [CNT_W-1:0]  wk_limit
);
  logic bad_ctl_wr;
  assign bad_ctl_wr = bus_sel && bus_wr && (bus_addr == '0) &&
                      ((bus_wdata[31:24] != 8'hA5) || !bus_wdata[0]);

  AST_SHDN_CUTS: assert property (@(posedge clk) disable iff (!rst_n) shdn_accept |=> !pwr_en); // R2
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n) (bad_ctl_wr && pwr_en) |=> pwr_en); // R3
  AST_DEBOUNCE: assert property (@(posedge clk) disable iff (!rst_n) (pin_wake && wk_limit != '0) |-> $past(pin_cond)); // R7
  AST_WAKE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n) wake_any |=> pwr_en); // R8
  AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_en) |-> (status_q != '0)); // R9
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (status_rd && !wake_any) |=> (status_q == '0)); // R10
  AST_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pwr_en && !shdn_accept) |=> pwr_en); // R11
  AST_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n) (pwr_en && !status_rd) |=> $stable(status_q)); // R11
endmodule

bind shdn_wake_ctrl swc_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwr_en(pwr_en),
  .shdn_accept(shdn_accept), .status_rd(status_rd), .pin_cond(pin_cond),
  .pin_wake(pin_wake), .wake_any(wake_any), .status_q(status_q),
  .wk_limit(wk_limit)
);

// File: tb/shdn_wake_ctrl_bench.sv
`timescale 1ns/1ps
module shdn_wake_ctrl_bench;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wake_pin = 1'b0, rtt_evt = 1'b0, rtc_evt = 1'b0;
  logic pwr_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  shdn_wake_ctrl #(.ADDR_W(AW), .CNT_W(4)) u_shdn_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_pin(wake_pin), .rtt_evt(rtt_evt), .rtc_evt(rtc_evt), .pwr_en(pwr_en)
  );

  // expected status word built from flags, independent of the RTL packing
  function automatic logic [31:0] st(input bit p, input bit t, input bit c);
    return (p ? 32'h1 : 32'h0) | (t ? 32'h0001_0000 : 32'h0) | (c ? 32'h0002_0000 : 32'h0);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data while a read is on the bus
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard-empty actual=%h expected=none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(bus_rdata, e.v, e.tag);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.v = exp; e.tag = tag;
    sb.push_back(e);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse(input bit t, input bit c);
    @(posedge clk); #1;
    rtt_evt = t; rtc_evt = c;
    @(posedge clk); #1;
    rtt_evt = 0; rtc_evt = 0;
  endtask

  task automatic shutdown();
    wr(4'h0, 32'hA500_0001);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(32'(pwr_en), 32'd1, "R1 pwr_en after reset");
    rd(4'h8, 32'h0, "R1 status after reset");
    rd(4'h4, 32'h0, "R1 mode after reset");
    rd(4'h0, 32'h0, "R3 control reads zero");

    // R4 mode readback and masking
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, 32'h0003_00F7, "R4 mode masked readback");
    wr(4'h4, 32'h0003_0001);
    rd(4'h4, 32'h0003_0001, "R4 mode readback");

    // R3 bad key and missing command bit
    wr(4'h0, 32'h5A00_0001);
    edges(2);
    chk(32'(pwr_en), 32'd1, "R3 wrong key ignored");
    wr(4'h0, 32'hA500_0000);
    edges(2);
    chk(32'(pwr_en), 32'd1, "R3 bit0 clear ignored");

    // R11 events while on
    pulse(1, 1);
    wake_pin = 1; edges(2); wake_pin = 0;
    chk(32'(pwr_en), 32'd1, "R11 power stays on");
    rd(4'h8, 32'h0, "R11 no status while on");

    // R2 shutdown, R5 high mode with N=0
    shutdown();
    chk(32'(pwr_en), 32'd0, "R2 shutdown takes effect");
    edges(2);
    chk(32'(pwr_en), 32'd0, "R2 stays off");
    wake_pin = 1;
    chk(32'(pwr_en), 32'd0, "R5 not yet on before edge");
    edges(1);
    chk(32'(pwr_en), 32'd1, "R5 high-level wake next edge");
    rd(4'h8, st(1, 0, 0), "R9 pin status bit");
    rd(4'h8, 32'h0, "R10 status cleared by read");

    // R7 low mode, N=3, with a break
    wr(4'h4, 32'h0000_0032);
    shutdown();
    wake_pin = 0;
    edges(2);
    wake_pin = 1;
    edges(1);
    chk(32'(pwr_en), 32'd0, "R7 broken run no wake");
    wake_pin = 0;
    edges(3);
    chk(32'(pwr_en), 32'd0, "R7 N samples not enough");
    edges(1);
    chk(32'(pwr_en), 32'd1, "R7 wake on N+1 sample");
    rd(4'h8, st(1, 0, 0), "R9 pin status after debounce");

    // R6 any-level mode, reference 0
    wr(4'h4, 32'h0000_0003);
    shutdown();
    edges(3);
    chk(32'(pwr_en), 32'd0, "R6 same level no wake");
    wake_pin = 1;
    edges(1);
    chk(32'(pwr_en), 32'd1, "R6 level change wakes");
    rd(4'h8, st(1, 0, 0), "R6 pin status");

    // R6 any-level mode, reference 1
    shutdown();
    edges(2);
    chk(32'(pwr_en), 32'd0, "R6 ref high holds off");
    wake_pin = 0;
    edges(1);
    chk(32'(pwr_en), 32'd1, "R6 fall wakes from ref high");
    rd(4'h8, st(1, 0, 0), "R6 pin status ref high");

    // R8 clock only; timer and pin disabled
    wr(4'h4, 32'h0002_0000);
    shutdown();
    wake_pin = 1; edges(1); wake_pin = 0;
    pulse(1, 0);
    edges(1);
    chk(32'(pwr_en), 32'd0, "R8 disabled sources ignored");
    pulse(0, 1);
    chk(32'(pwr_en), 32'd1, "R8 clock event wakes");
    rd(4'h8, st(0, 0, 1), "R9 clock status bit");

    // R8 timer only
    wr(4'h4, 32'h0001_0000);
    shutdown();
    pulse(0, 1);
    chk(32'(pwr_en), 32'd0, "R8 disabled clock ignored");
    pulse(1, 0);
    chk(32'(pwr_en), 32'd1, "R8 timer event wakes");
    rd(4'h8, st(0, 1, 0), "R9 timer status bit");

    // R9 simultaneous sources
    wr(4'h4, 32'h0003_0000);
    shutdown();
    pulse(1, 1);
    chk(32'(pwr_en), 32'd1, "R9 both events wake");
    rd(4'h8, st(0, 1, 1), "R9 both status bits");
    rd(4'h8, 32'h0, "R10 cleared after combined read");

    // R5 undefined mode code never wakes from pin
    wr(4'h4, 32'h0000_0005);
    rd(4'h4, 32'h0000_0005, "R4 mode code 5 readback");
    shutdown();
    wake_pin = 1; edges(2); wake_pin = 0; edges(2);
    chk(32'(pwr_en), 32'd0, "R5 mode 5 pin ignored");
    wake_pin = 1;
    wr(4'h4, 32'h0000_0001);
    edges(1);
    chk(32'(pwr_en), 32'd1, "R5 high mode set while off wakes");
    rd(4'h8, st(1, 0, 0), "R9 pin status after late mode");

    edges(2);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard-leftover actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule